// File: doc/BRIEF.md
# DMA Physical Address Formation Unit

This unit produces the 24-bit physical memory address used by one DMA channel. The address is built from an 8-bit page register and a 16-bit current address counter. A parameter sets the channel kind when the unit is built. A byte channel moves one byte per count step and stays within a 64 KiB page. A word channel moves 16 bits per count step, so it can reach a 128 KiB page.

Software writes the page register and loads the counter with a byte offset inside the page. The transfer engine then pulses a step strobe once per transfer. The counter counts up, or down when the direction input is set. It wraps inside its page and never carries into the page register. A one-cycle pulse reports each wrap, so the engine can detect a page boundary. Byte-lane enables come with the address.

Top module: `dma_phys_addr_gen`

## Requirements
- R1: Reset clears the page register and the counter and holds the wrap pulse low. The address then reads 0, and byte enables read 2'b11 in word mode and 2'b01 in byte mode.
- R2: In byte mode, address bits 23:16 equal the page register and address bits 15:0 equal the counter.
- R3: In word mode, address bits 23:17 equal page bits 7:1, address bits 16:1 equal the counter, and address bit 0 is always 0.
- R4: In word mode, the value written to page bit 0 has no effect on the address.
- R5: A counter load takes a 17-bit byte offset. Word mode stores offset bits 16:1. Byte mode stores offset bits 15:0 and ignores bit 16.
- R6: A step strobe adds one to the counter when the direction input is 0 and subtracts one when it is 1. The new address appears after the clock edge that takes the strobe. With no strobe, the counter holds.
- R7: The counter wraps modulo 2^16 (0xFFFF to 0 going up, 0 to 0xFFFF going down), and the page bits of the address do not change.
- R8: A step that wraps the counter raises the wrap output for exactly the one cycle after that clock edge. Back-to-back wrapping steps give a pulse on each.
- R9: Byte enables are 2'b11 in word mode. In byte mode they are 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R10: A load and a step in the same cycle apply only the load, and no wrap pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | PAGE_W | Page register write value |
| cnt_load | input | 1 | Counter load strobe |
| cnt_load_ofs | input | CNT_W+1 | Byte offset within the page for a load |
| step | input | 1 | One transfer done; advance the counter |
| step_down | input | 1 | 1 = decrement on a step, 0 = increment |
| phys_addr | output | PAGE_W+CNT_W | Physical byte address |
| byte_en | output | 2 | Active byte lanes |
| wrap_pulse | output | 1 | One-cycle pulse after the counter wraps |

## Verification
The hardest case to reach is a wrap at the page edge. The counter needs 65536 steps to get there from a normal start. The bench instead loads offset 0x1FFFF, which puts both channel kinds at 0xFFFF. It then steps up and down back-to-back to produce wraps on consecutive cycles in both directions, and checks that the page bits stay fixed. A word-mode and a byte-mode instance run side by side on the same stimulus. This shows the effect of the ignored page bit and the ignored top load bit, one mode against the other.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    // Counter action chosen each cycle; load has priority over a step
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_INC  = 2'd2,
        CNT_DEC  = 2'd3
    } cnt_op_e;

    function automatic cnt_op_e pick_op(input logic load, input logic stp, input logic down);
        if (load)      return CNT_LOAD;
        else if (!stp) return CNT_HOLD;
        else if (down) return CNT_DEC;
        else           return CNT_INC;
    endfunction

endpackage

// File: rtl/dpa_page_reg.sv
module dpa_page_reg #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } page_state_t;

    page_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.page = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.page;

endmodule

// File: rtl/dpa_counter.sv
module dpa_counter
    import dpa_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit WORD_MODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W:0]   load_ofs,
    input  logic             stp,
    input  logic             down,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] load_val;
    cnt_op_e          op;

    // Word channels count 16-bit units: drop the byte-select bit
    generate
        if (WORD_MODE) begin : g_word_load
            logic unused_ofs_lsb;
            assign unused_ofs_lsb = load_ofs[0];
            assign load_val       = load_ofs[CNT_W:1];
        end else begin : g_byte_load
            logic unused_ofs_msb;
            assign unused_ofs_msb = load_ofs[CNT_W];
            assign load_val       = load_ofs[CNT_W-1:0];
        end
    endgenerate

    always_comb begin
        op        = pick_op(load, stp, down);
        st_d      = st_q;
        st_d.wrap = 1'b0;
        case (op)
            CNT_LOAD: st_d.cnt = load_val;
            CNT_INC: begin
                st_d.cnt  = st_q.cnt + ONE;
                st_d.wrap = &st_q.cnt;
            end
            CNT_DEC: begin
                st_d.cnt  = st_q.cnt - ONE;
                st_d.wrap = (st_q.cnt == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign wrap = st_q.wrap;

endmodule

// File: rtl/dpa_compose.sv
module dpa_compose #(
    parameter int PAGE_W    = 8,
    parameter int CNT_W     = 16,
    parameter bit WORD_MODE = 1'b1
) (
    input  logic [PAGE_W-1:0]       page,
    input  logic [CNT_W-1:0]        cnt,
    output logic [PAGE_W+CNT_W-1:0] addr,
    output logic [1:0]              lanes
);

    generate
        if (WORD_MODE) begin : g_word
            logic unused_page_lsb;
            assign unused_page_lsb = page[0];
            assign addr  = {page[PAGE_W-1:1], cnt, 1'b0};
            assign lanes = 2'b11;
        end else begin : g_byte
            assign addr  = {page, cnt};
            assign lanes = cnt[0] ? 2'b10 : 2'b01;
        end
    endgenerate

endmodule

// File: rtl/dma_phys_addr_gen.sv
module dma_phys_addr_gen #(
    parameter bit WORD_MODE = 1'b1,
    parameter int PAGE_W    = 8,
    parameter int CNT_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    page_we,
    input  logic [PAGE_W-1:0]       page_wdata,
    input  logic                    cnt_load,
    input  logic [CNT_W:0]          cnt_load_ofs,
    input  logic                    step,
    input  logic                    step_down,
    output logic [PAGE_W+CNT_W-1:0] phys_addr,
    output logic [1:0]              byte_en,
    output logic                    wrap_pulse
);

    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  cnt_q;

    dpa_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wdata (page_wdata),
        .page  (page_q)
    );

    dpa_counter #(.CNT_W(CNT_W), .WORD_MODE(WORD_MODE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_ofs (cnt_load_ofs),
        .stp      (step),
        .down     (step_down),
        .cnt      (cnt_q),
        .wrap     (wrap_pulse)
    );

    dpa_compose #(.PAGE_W(PAGE_W), .CNT_W(CNT_W), .WORD_MODE(WORD_MODE)) u_comp (
        .page  (page_q),
        .cnt   (cnt_q),
        .addr  (phys_addr),
        .lanes (byte_en)
    );

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
    parameter bit WORD_MODE = 1'b1,
    parameter int PAGE_W    = 8,
    parameter int CNT_W     = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    page_we,
    input logic                    cnt_load,
    input logic [CNT_W:0]          cnt_load_ofs,
    input logic                    step,
    input logic                    step_down,
    input logic [PAGE_W+CNT_W-1:0] phys_addr,
    input logic [1:0]              byte_en,
    input logic                    wrap_pulse
);

    localparam int AW    = PAGE_W + CNT_W;
    localparam int PG_LO = CNT_W + (WORD_MODE ? 1 : 0);

    logic [CNT_W-1:0] cnt_view;
    logic [CNT_W-1:0] ld_view;
    logic             unused_ofs_bits;

    assign cnt_view        = WORD_MODE ? phys_addr[CNT_W:1] : phys_addr[CNT_W-1:0];
    assign ld_view         = WORD_MODE ? cnt_load_ofs[CNT_W:1] : cnt_load_ofs[CNT_W-1:0];
    assign unused_ofs_bits = cnt_load_ofs[0] ^ cnt_load_ofs[CNT_W];

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !page_we |=> $stable(phys_addr[AW-1:PG_LO])); // R7

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !step_down && !cnt_load) |=> cnt_view == CNT_W'($past(cnt_view) + 1'b1)); // R6

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && step_down && !cnt_load) |=> cnt_view == CNT_W'($past(cnt_view) - 1'b1)); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_view == $past(ld_view)) && !wrap_pulse); // R10

    AST_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> ($past(step) && !$past(cnt_load))); // R8

    AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> ((cnt_view == '0) || (&cnt_view))); // R7

    generate
        if (WORD_MODE) begin : g_word_chk
            AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
                (byte_en == 2'b11) && !phys_addr[0]); // R3
        end else begin : g_byte_chk
            AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(byte_en) && (byte_en[1] == phys_addr[0])); // R9
        end
    endgenerate

endmodule

bind dma_phys_addr_gen dpa_checker #(
    .WORD_MODE (WORD_MODE),
    .PAGE_W    (PAGE_W),
    .CNT_W     (CNT_W)
) u_dpa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .page_we      (page_we),
    .cnt_load     (cnt_load),
    .cnt_load_ofs (cnt_load_ofs),
    .step         (step),
    .step_down    (step_down),
    .phys_addr    (phys_addr),
    .byte_en      (byte_en),
    .wrap_pulse   (wrap_pulse)
);

// File: tb/sim_dma_phys_addr_gen.sv
module sim_dma_phys_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic        cnt_load = 1'b0;
    logic [16:0] cnt_load_ofs = '0;
    logic        step = 1'b0;
    logic        step_down = 1'b0;
    logic [23:0] pa_w, pa_b;
    logic [1:0]  be_w, be_b;
    logic        wr_w, wr_b;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_phys_addr_gen #(.WORD_MODE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .cnt_load(cnt_load), .cnt_load_ofs(cnt_load_ofs), .step(step),
        .step_down(step_down), .phys_addr(pa_w), .byte_en(be_w), .wrap_pulse(wr_w)
    );

    dma_phys_addr_gen #(.WORD_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .page_we(page_we), .page_wdata(page_wdata),
        .cnt_load(cnt_load), .cnt_load_ofs(cnt_load_ofs), .step(step),
        .step_down(step_down), .phys_addr(pa_b), .byte_en(be_b), .wrap_pulse(wr_b)
    );

    typedef struct {
        logic [23:0] pw;
        logic [1:0]  bw;
        logic        ww;
        logic [23:0] pb;
        logic [1:0]  bb;
        logic        wb;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state, kept from the requirements
    logic [7:0]  m_page = '0;
    logic [15:0] m_cw = '0;
    logic [15:0] m_cb = '0;

    task automatic check(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [7:0] wd, input logic ld,
                         input logic [16:0] ofs, input logic st, input logic dn,
                         input string tag);
        exp_t e;
        logic ww, wb;
        @(negedge clk);
        page_we = we; page_wdata = wd; cnt_load = ld; cnt_load_ofs = ofs;
        step = st; step_down = dn;
        ww = 1'b0; wb = 1'b0;
        if (we) m_page = wd;
        if (ld) begin
            m_cw = ofs[16:1];
            m_cb = ofs[15:0];
        end else if (st) begin
            ww = dn ? (m_cw == 16'h0000) : (m_cw == 16'hFFFF);
            wb = dn ? (m_cb == 16'h0000) : (m_cb == 16'hFFFF);
            m_cw = dn ? m_cw - 16'd1 : m_cw + 16'd1;
            m_cb = dn ? m_cb - 16'd1 : m_cb + 16'd1;
        end
        e.pw = {m_page[7:1], m_cw, 1'b0};
        e.bw = 2'b11;
        e.ww = ww;
        e.pb = {m_page, m_cb};
        e.bb = m_cb[0] ? 2'b10 : 2'b01;
        e.wb = wb;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare after each edge that follows a driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "word addr", pa_w, e.pw);
                check(e.tag, "word lanes", {22'h0, be_w}, {22'h0, e.bw});
                check(e.tag, "word wrap", {23'h0, wr_w}, {23'h0, e.ww});
                check(e.tag, "byte addr", pa_b, e.pb);
                check(e.tag, "byte lanes", {22'h0, be_b}, {22'h0, e.bb});
                check(e.tag, "byte wrap", {23'h0, wr_b}, {23'h0, e.wb});
            end
        end
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "word addr", pa_w, 24'h0);
        check("R1", "word lanes", {22'h0, be_w}, 24'h3);
        check("R1", "word wrap", {23'h0, wr_w}, 24'h0);
        check("R1", "byte addr", pa_b, 24'h0);
        check("R1", "byte lanes", {22'h0, be_b}, 24'h1);
        check("R1", "byte wrap", {23'h0, wr_b}, 24'h0);

        // R2 R3: page composition
        drive(1'b1, 8'h35, 1'b0, 17'h0, 1'b0, 1'b0, "R2");
        // R4: page 0x34 gives the same word address as 0x35
        drive(1'b1, 8'h34, 1'b0, 17'h0, 1'b0, 1'b0, "R4");
        drive(1'b1, 8'hA7, 1'b0, 17'h0, 1'b0, 1'b0, "R3");
        // R5: load a byte offset with bit 16 set
        drive(1'b0, 8'h00, 1'b1, 17'h1_2345, 1'b0, 1'b0, "R5");
        // R6: steps both ways and hold
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b0, "R6");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b0, "R6");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b0, "R6");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b1, "R6");
        idle("R6");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b1, "R6");
        // R9: lane choice on even and odd byte addresses
        drive(1'b0, 8'h00, 1'b1, 17'h0_0FFE, 1'b0, 1'b0, "R9");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b0, "R9");
        // R7 R8: wrap at the page edge, both directions, back to back
        drive(1'b0, 8'h00, 1'b1, 17'h1_FFFF, 1'b0, 1'b0, "R7");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b0, "R8");
        idle("R8");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b1, "R8");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b0, "R8");
        drive(1'b0, 8'h00, 1'b0, 17'h0, 1'b1, 1'b1, "R7");
        // R10: load beats a wrapping step
        drive(1'b0, 8'h00, 1'b1, 17'h0_1001, 1'b1, 1'b1, "R10");
        drive(1'b0, 8'h00, 1'b1, 17'h1_FFFF, 1'b0, 1'b0, "R10");
        drive(1'b0, 8'h00, 1'b1, 17'h0_0002, 1'b1, 1'b0, "R10");
        // R4 R6: page write of bit 0 while stepping
        drive(1'b1, 8'h5B, 1'b0, 17'h0, 1'b1, 1'b0, "R4");
        drive(1'b1, 8'h5A, 1'b0, 17'h0, 1'b1, 1'b0, "R4");
        @(negedge clk);
        page_we = 1'b0; cnt_load = 1'b0; step = 1'b0; step_down = 1'b0;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule